// File: doc/BRIEF.md
# DDR3 Refresh Burst Scheduler

This block is the refresh timer on the controller side of a DDR3 memory controller. Once the initialization sequence is finished and the enable input goes high, it counts clocks since the most recent REFRESH. Refreshes are postponed and then issued as a burst of several back-to-back commands. The longest legal gap between bursts equals the burst length times the average refresh interval, minus the recovery times spent inside the burst. The block raises its request a programmable margin before that deadline. This margin gives the command path time to close any open rows.

During a burst the block holds a busy flag that shuts out every other command. Successive REFRESH commands in the burst are spaced by the refresh recovery time. A REFRESH counts as issued on any clock where the request and the bus grant are both high. Separately, an activate-allowed flag tells the command path when an ACTIVATE may go out. That is only outside a burst, and only after the recovery time has elapsed since the latest REFRESH. The block does not encode commands, precharge banks or move data. It assumes all banks are idle whenever it is granted the bus.

Top module: `rfsh_sched`

## Requirements
- R1: While the synchronous reset is high, and on the first sample after it, refresh request, busy and activate-allowed are all 0.
- R2: While the enable is low, all three outputs stay 0 whatever the grant input does.
- R3: The clock edge that first samples the enable high counts as a burst that has just completed. Activate-allowed becomes 1 after T_RFC edges (edges counted from and including that one).
- R4: The deadline is DEADLINE = BURST*T_REFI - (BURST-1)*T_RFC clocks. The refresh request, together with busy, rises THRESH = DEADLINE - MARGIN edges after the edge that issued the last REFRESH of the previous burst. After enable, it rises THRESH edges after the enabling edge.
- R5: A REFRESH is issued on a clock where the request and the grant are both 1. Until then the request stays high. The request drops on the next sample.
- R6: Within a burst, each REFRESH after the first is requested T_RFC edges after the previous one was issued.
- R7: Exactly BURST refreshes are issued per burst. Busy stays high from the first request until the edge that issues the final REFRESH, and is 0 on the sample after that edge.
- R8: Activate-allowed is 0 whenever busy is 1. It returns to 1 T_RFC edges after the final REFRESH of a burst.
- R9: A grant while no request is pending has no effect. It changes no output and does not move the next request.
- R10: Dropping the enable returns the block to its idle state on the next edge, with all outputs 0. Raising it again restarts the timing exactly as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | High once memory initialization has finished |
| grant_i | input | 1 | Command bus handed to the refresh scheduler this clock |
| ref_req_o | output | 1 | A REFRESH should be issued |
| busy_o | output | 1 | Burst in progress; block all other commands |
| act_ok_o | output | 1 | An ACTIVATE is legal this clock |

## Verification
All three outputs are registered and are derived from the next-state values, so each responds on the same edge that samples the stimulus. A request or activate-allowed change is due an exact number of edges after its reference edge: THRESH or T_RFC edges after an enabling edge or an issuing edge. The bench drives and samples one time unit after each rising edge. Each timing check counts edges from the reference sample until the output is seen high, and compares that count with a value derived from the bench's own copies of the parameters. Busy falling and the request dropping after a grant are checked on the very next sample.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    RS_OFF   = 2'd0,
    RS_COUNT = 2'd1,
    RS_BURST = 2'd2
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_age_counter.sv
// Clocks elapsed since the latest REFRESH (or since enable), saturating.
module rfsh_age_counter #(
  parameter int AGE_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  output logic [AGE_W-1:0] age_q,
  output logic [AGE_W-1:0] age_n
);
  always_comb begin
    if (!run)                  age_n = '0;
    else if (restart)          age_n = AGE_W'(1);
    else if (age_q != '1)      age_n = age_q + AGE_W'(1);
    else                       age_n = age_q;
  end

  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else     age_q <= age_n;
  end

  AST_IDLE_AGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> age_q == '0);  // R2
endmodule

// File: rtl/rfsh_burst_fsm.sv
module rfsh_burst_fsm
  import rfsh_pkg::*;
#(
  parameter int BURST  = 4,
  parameter int AGE_W  = 14,
  parameter int THRESH = 5216
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     issue,
  input  logic [AGE_W-1:0]         age_q,
  input  logic [AGE_W-1:0]         age_n,
  output rfsh_state_e              state_q,
  output rfsh_state_e              state_n,
  output logic [$clog2(BURST+1)-1:0] left_n
);
  localparam int LW = $clog2(BURST+1);
  localparam logic [LW-1:0]    LEFT_FULL = LW'(BURST);
  localparam logic [AGE_W-1:0] THR_W     = AGE_W'(THRESH);

  logic [LW-1:0] left_q;

  always_comb begin
    state_n = state_q;
    left_n  = left_q;
    if (!en) begin
      state_n = RS_OFF;
      left_n  = '0;
    end else begin
      case (state_q)
        RS_OFF:   state_n = RS_COUNT;
        RS_COUNT: if (age_n >= THR_W) begin
                    state_n = RS_BURST;
                    left_n  = LEFT_FULL;
                  end
        RS_BURST: if (issue) begin
                    if (left_q == LW'(1)) begin
                      state_n = RS_COUNT;
                      left_n  = '0;
                    end else begin
                      left_n  = left_q - LW'(1);
                    end
                  end
        default:  state_n = RS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_OFF;
      left_q  <= '0;
    end else begin
      state_q <= state_n;
      left_q  <= left_n;
    end
  end

  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (rst)
    left_q <= LEFT_FULL);  // R7
  AST_BURST_PENDING: assert property (@(posedge clk) disable iff (rst)
    state_q == RS_BURST |-> left_q != '0);  // R7
  AST_COUNT_BEFORE_THRESH: assert property (@(posedge clk) disable iff (rst)
    state_q == RS_COUNT |-> age_q < THR_W);  // R4
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int T_RFC  = 320,
  parameter int T_REFI = 1560,
  parameter int BURST  = 4,
  parameter int MARGIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic grant_i,
  output logic ref_req_o,
  output logic busy_o,
  output logic act_ok_o
);
  localparam int DEADLINE = BURST*T_REFI - (BURST-1)*T_RFC;
  localparam int THRESH   = DEADLINE - MARGIN;
  localparam int AGE_W    = $clog2(DEADLINE+1) + 1;
  localparam int LW       = $clog2(BURST+1);
  localparam logic [AGE_W-1:0] RFC_W     = AGE_W'(T_RFC);
  localparam logic [LW-1:0]    LEFT_FULL = LW'(BURST);

  logic [AGE_W-1:0] age_q, age_n;
  rfsh_state_e      state_q, state_n;
  logic [LW-1:0]    left_n;
  logic             issue, start;
  logic             req_q, busy_q, act_q;

  assign issue = grant_i & req_q;
  assign start = en_i & (state_q == RS_OFF);

  rfsh_age_counter #(.AGE_W(AGE_W)) age_i (
    .clk(clk), .rst(rst), .run(en_i), .restart(issue | start),
    .age_q(age_q), .age_n(age_n)
  );

  rfsh_burst_fsm #(.BURST(BURST), .AGE_W(AGE_W), .THRESH(THRESH)) fsm_i (
    .clk(clk), .rst(rst), .en(en_i), .issue(issue),
    .age_q(age_q), .age_n(age_n),
    .state_q(state_q), .state_n(state_n), .left_n(left_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      req_q  <= (state_n == RS_BURST) && ((left_n == LEFT_FULL) || (age_n >= RFC_W));
      busy_q <= (state_n == RS_BURST);
      act_q  <= (state_n == RS_COUNT) && (age_n >= RFC_W);
    end
  end

  assign ref_req_o = req_q;
  assign busy_o    = busy_q;
  assign act_ok_o  = act_q;

  AST_REQ_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_q |-> busy_q);  // R7
  AST_NO_ACT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !act_q);  // R8
  AST_ACT_AFTER_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    act_q |-> age_q >= RFC_W);  // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    state_q == RS_OFF |-> !req_q && !busy_q && !act_q);  // R2
  AST_ISSUE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    issue && en_i |=> !req_q);  // R5
endmodule

// File: tb/rfsh_sched_tb_top.sv
`timescale 1ns/1ps
module rfsh_sched_tb_top;
  localparam int T_RFC  = 20;
  localparam int T_REFI = 60;
  localparam int BURST  = 4;
  localparam int MARGIN = 8;
  localparam int DEADLINE = BURST*T_REFI - (BURST-1)*T_RFC;
  localparam int THRESH   = DEADLINE - MARGIN;
  localparam int LIMIT    = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic grant = 1'b0;
  logic req, busy, act;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rfsh_sched #(.T_RFC(T_RFC), .T_REFI(T_REFI), .BURST(BURST), .MARGIN(MARGIN)) dut_i (
    .clk(clk), .rst(rst), .en_i(en), .grant_i(grant),
    .ref_req_o(req), .busy_o(busy), .act_ok_o(act)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic check_outs(input string tag, input int r, input int b, input int a);
    check({tag, " req"}, int'(req), r);
    check({tag, " busy"}, int'(busy), b);
    check({tag, " act"}, int'(act), a);
  endtask

  // sel 0: request, sel 1: activate-allowed
  task automatic edges_until(input int sel, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!((sel == 0) ? req : act) && n < LIMIT);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; grant = 1'b0;
    repeat (3) step();
    check_outs("R1 in reset", 0, 0, 0);
    rst = 1'b0;
    step();
    check_outs("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    grant = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step();
      if (req || busy || act) seen++;
      grant = ~grant;
    end
    check("R2 outputs while disabled", seen, 0);
    grant = 1'b0;
  endtask

  task automatic t_first_burst();
    int n;
    en = 1'b1;
    edges_until(1, n);
    check("R3 act after enable", n, T_RFC);
    edges_until(0, n);
    check("R4 first request", n + T_RFC, THRESH);
    check_outs("R8 burst start", 1, 1, 0);
    for (int i = 0; i < 7; i++) begin
      step();
      check("R5 request held without grant", int'(req), 1);
    end
    grant = 1'b1;
    step();
    check_outs("R5 after issue", 0, 1, 0);
    edges_until(0, n);
    check("R6 second spacing", n + 1, T_RFC);
    for (int k = 0; k < BURST - 2; k++) begin
      edges_until(0, n);
      check("R6 later spacing", n, T_RFC);
      check("R8 act low in burst", int'(act), 0);
    end
    step();
    check_outs("R7 burst over", 0, 0, 0);
    edges_until(1, n);
    check("R8 act after final refresh", n + 1, T_RFC);
  endtask

  task automatic t_second_burst();
    int n;
    int drops = 0;
    int issues = 0;
    int span = 0;
    // grant held high through the whole wait: R9
    for (int i = 0; i < THRESH - T_RFC - 1; i++) begin
      step();
      if (req || !act) drops++;
    end
    check("R9 spurious grant ignored", drops, 0);
    step();
    check("R4 second request on time", int'(req), 1);
    check("R4 busy with request", int'(busy), 1);
    while (busy && span < LIMIT) begin
      if (req) issues++;
      step();
      span++;
    end
    check("R7 refresh count", issues, BURST);
    check("R7 busy span", span, (BURST-1)*T_RFC + 1);
  endtask

  task automatic t_disable();
    int n;
    int seen = 0;
    repeat (30) step();
    en = 1'b0;
    step();
    check_outs("R10 disabled", 0, 0, 0);
    for (int i = 0; i < 50; i++) begin
      step();
      if (req || busy || act) seen++;
    end
    check("R10 quiet while off", seen, 0);
    en = 1'b1;
    edges_until(1, n);
    check("R10 act after re-enable", n, T_RFC);
    edges_until(0, n);
    check("R10 request after re-enable", n + T_RFC, THRESH);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_first_burst();
    t_second_burst();
    t_disable();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule